// File: doc/BRIEF.md
# Q15 Fractional Sequential Divider

This block divides one signed Q15 fraction by another and returns a signed Q15 quotient. It is a multi-cycle unit: a start pulse hands it a 16-bit dividend and a 16-bit divisor. It records the sign of each operand and turns both into 17-bit magnitudes. It then places the dividend magnitude in a wide accumulator, shifted up so that the bits line up with the divisor. From there it runs one shift-and-conditional-subtract step per clock. Each step retires one quotient bit. At the end the quotient is taken from the low end of the accumulator and negated when the operand signs differ.

The result can only be a proper fraction. The block therefore accepts only divisions where the divisor magnitude is strictly larger than the dividend magnitude. Any other request, including a zero divisor, finishes at once with the error flag raised and a zero quotient.

A parameter picks one of two equivalent schedules:
- The default loads the dividend shifted by 15 and runs 16 steps.
- The alternative loads it shifted by 16 and runs 15 steps, which saves one cycle.

Top module: `q15_seq_div`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `quotient` is 0x0000.
- R2: For a valid request, the quotient magnitude is |dividend|·2^15 / |divisor|, truncated toward zero. Operands and result are two's complement, with bit 15 as the sign.
- R3: When exactly one operand is negative, the quotient is the two's-complement negation of that magnitude. A zero magnitude stays 0x0000.
- R4: A divisor of 0x8000 (-32768) is handled as magnitude 32768 without overflow. For example, 0x7FFF divided by 0x8000 gives 0x8001.
- R5: A request is rejected when |divisor| <= |dividend|, which includes a zero divisor. A rejected request sets `done` and `err` to 1 one clock after it is accepted, with `quotient` 0x0000 and no busy period.
- R6: A valid request raises `busy` from the accepting edge. `done` rises STEPS clock edges after that edge, together with `err` = 0. STEPS is 16 with the default schedule and 15 with the alternative one.
- R7: A `start` pulse that arrives while `busy` is 1 is ignored. The running result and its timing are unchanged, and no second completion follows.
- R8: `done` is high for exactly one cycle per accepted request. `quotient` and `err` keep their values until the next completion.
- R9: The alternative schedule (shift by 16, 15 steps) returns the same quotient and error as the default schedule for every operand pair. For example, 0x0400 divided by 0x2000 gives 0x1000 under both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted only while idle |
| dividend | input | W | Signed Q15 numerator |
| divisor | input | W | Signed Q15 denominator |
| busy | output | 1 | High while the subtract loop runs |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Range or zero-divisor error of the last completion |
| quotient | output | W | Signed Q15 result of the last completion |

## Verification
The bench builds two instances at W = 16 and drives them side by side with the same operands. One uses the default 16-step schedule and the other the 15-step schedule, so every result also checks that the two agree and that each has its own latency. Directed pairs reach the cases a random draw rarely hits: the -32768 divisor, a dividend of -32768, equal and opposite magnitudes, a zero divisor, a zero dividend and the smallest non-zero quotient. The random pairs are about half biased to small dividends so that valid and rejected requests are both frequent.

// File: rtl/q15_div_pkg.sv
package q15_div_pkg;
    // Iteration schedule of the conditional-subtract loop
    typedef enum logic {
        SCHED_SHIFT15 = 1'b0,   // dividend << (W-1), W steps
        SCHED_SHIFT16 = 1'b1    // dividend << W, W-1 steps
    } sched_e;
endpackage

// File: rtl/q15_sign_mag.sv
module q15_sign_mag #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    output logic [W:0]   mag,
    output logic         neg
);
    logic [W:0] ext;

    always_comb begin
        ext = {value[W-1], value};
        neg = value[W-1];
        mag = neg ? ((W+1)'(0) - ext) : ext;
    end
endmodule

// File: rtl/q15_csub_step.sv
module q15_csub_step #(
    parameter int W = 16
) (
    input  logic [2*W:0] acc_in,
    input  logic [W:0]   dmag,
    output logic [2*W:0] acc_out
);
    localparam int ACC_W = 2*W + 1;
    localparam int ALIGN = W - 1;
    localparam int PAD   = ACC_W + 1 - (W + 1) - ALIGN;

    logic [ACC_W:0] aligned;
    logic [ACC_W:0] diff;

    always_comb begin
        aligned = {{PAD{1'b0}}, dmag, {ALIGN{1'b0}}};
        diff    = {1'b0, acc_in} - aligned;
        if (!diff[ACC_W]) begin
            acc_out = (diff[ACC_W-1:0] << 1) | ACC_W'(1);
        end else begin
            acc_out = acc_in << 1;
        end
    end
endmodule

// File: rtl/q15_seq_div.sv
module q15_seq_div
    import q15_div_pkg::*;
#(
    parameter int     W     = 16,
    parameter sched_e SCHED = SCHED_SHIFT15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         err,
    output logic [W-1:0] quotient
);
    localparam int ALT       = (SCHED == SCHED_SHIFT16) ? 1 : 0;
    localparam int MAG_W     = W + 1;
    localparam int ACC_W     = 2*W + 1;
    localparam int PRE_SHIFT = W - 1 + ALT;
    localparam int STEPS     = W - ALT;
    localparam int CNT_W     = $clog2(STEPS + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             err;
        logic             neg;
        logic [CNT_W-1:0] cnt;
        logic [MAG_W-1:0] dmag;
        logic [ACC_W-1:0] acc;
        logic [W-1:0]     quo;
    } regs_t;

    regs_t r_q, r_d;

    logic [MAG_W-1:0] a_mag, b_mag;
    logic             a_neg, b_neg;
    logic [ACC_W-1:0] step_acc;
    logic [W-1:0]     qmag;

    q15_sign_mag #(.W(W)) u_mag_num (.value(dividend), .mag(a_mag), .neg(a_neg));
    q15_sign_mag #(.W(W)) u_mag_den (.value(divisor),  .mag(b_mag), .neg(b_neg));

    q15_csub_step #(.W(W)) u_step (
        .acc_in (r_q.acc),
        .dmag   (r_q.dmag),
        .acc_out(step_acc)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        qmag     = '0;
        qmag[STEPS-1:0] = step_acc[STEPS-1:0];
        if (!r_q.busy) begin
            if (start) begin
                if (b_mag == '0 || b_mag <= a_mag) begin
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.quo  = '0;
                end else begin
                    r_d.busy = 1'b1;
                    r_d.acc  = ACC_W'(a_mag) << PRE_SHIFT;
                    r_d.dmag = b_mag;
                    r_d.neg  = a_neg ^ b_neg;
                    r_d.cnt  = CNT_W'(STEPS);
                end
            end
        end else begin
            r_d.acc = step_acc;
            r_d.cnt = r_q.cnt - CNT_W'(1);
            if (r_q.cnt == CNT_W'(1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                r_d.err  = 1'b0;
                r_d.quo  = r_q.neg ? (W'(0) - qmag) : qmag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = r_q.busy;
    assign done     = r_q.done;
    assign err      = r_q.err;
    assign quotient = r_q.quo;
endmodule

// File: rtl/q15_div_checker.sv
module q15_div_checker
    import q15_div_pkg::*;
#(
    parameter int     W     = 16,
    parameter sched_e SCHED = SCHED_SHIFT15
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic         err,
    input logic [W-1:0] quotient
);
    localparam int STEPS = W - ((SCHED == SCHED_SHIFT16) ? 1 : 0);
    localparam int RC_W  = $clog2(STEPS + 2) + 1;

    function automatic logic [W:0] magof(input logic [W-1:0] v);
        logic [W:0] e;
        e = {v[W-1], v};
        return v[W-1] ? ((W+1)'(0) - e) : e;
    endfunction

    logic [W:0]      cap_am, cap_bm;
    logic            cap_neg;
    logic [RC_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_am  <= '0;
            cap_bm  <= '0;
            cap_neg <= 1'b0;
            run_q   <= '0;
        end else begin
            if (start && !busy) begin
                cap_am  <= magof(dividend);
                cap_bm  <= magof(divisor);
                cap_neg <= dividend[W-1] ^ divisor[W-1];
            end
            run_q <= busy ? run_q + RC_W'(1) : '0;
        end
    end

    // R8: completion pulse lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: results hold between completions
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(err)));

    // R5: error decided by magnitude comparison of the accepted operands
    a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == (cap_bm <= cap_am)));

    // R5: rejected request returns zero without a busy period
    a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (quotient == '0 && run_q == '0));

    // R6: valid request completes after exactly STEPS busy cycles
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (run_q == RC_W'(STEPS)));

    // R6: never busy while reporting completion
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: sign of a non-zero quotient follows the operand signs
    a_r3_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && quotient != '0) |-> (quotient[W-1] == cap_neg));
endmodule

bind q15_seq_div q15_div_checker #(.W(W), .SCHED(SCHED)) u_q15_div_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .dividend(dividend),
    .divisor (divisor),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .quotient(quotient)
);

// File: tb/test_q15_seq_div.sv
`timescale 1ns/1ps
module test_q15_seq_div;
    import q15_div_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] dividend, divisor;
    logic        busy_a, done_a, err_a;
    logic [15:0] quo_a;
    logic        busy_b, done_b, err_b;
    logic [15:0] quo_b;
    int          total = 0;
    int          bad   = 0;

    always #2 clk = ~clk;

    q15_seq_div #(.W(16), .SCHED(SCHED_SHIFT15)) i_q15_seq_div (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy_a), .done(done_a), .err(err_a), .quotient(quo_a));

    q15_seq_div #(.W(16), .SCHED(SCHED_SHIFT16)) i_q15_seq_div_alt (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy_b), .done(done_b), .err(err_b), .quotient(quo_b));

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference: {err, quotient}
    function automatic logic [16:0] model(input logic [15:0] a, input logic [15:0] b);
        int sa, sb, ma, mb, q;
        sa = int'($signed(a));
        sb = int'($signed(b));
        ma = (sa < 0) ? -sa : sa;
        mb = (sb < 0) ? -sb : sb;
        if (mb == 0 || mb <= ma) return {1'b1, 16'h0000};
        q = (ma * 32768) / mb;
        if ((sa < 0) != (sb < 0)) q = -q;
        return {1'b0, 16'(q)};
    endfunction

    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit poke, input string req);
        logic [16:0] exp;
        int          lat_a, lat_b, pulses_a, pulses_b;
        logic [15:0] qa, qb;
        logic        ea, eb;
        exp = model(a, b);
        lat_a = -1; lat_b = -1; pulses_a = 0; pulses_b = 0;
        qa = '0; qb = '0; ea = 1'b0; eb = 1'b0;
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        for (int cyc = 1; cyc <= 40; cyc++) begin
            @(negedge clk);
            if (cyc == 1) start = 1'b0;
            if (poke && cyc == 4) begin start = 1'b1; dividend = 16'h0001; divisor = 16'h7000; end
            if (poke && cyc == 5) start = 1'b0;
            if (cyc == 2 && !exp[16]) begin
                chk("R6", "busy during run", {30'd0, busy_a, busy_b}, 32'd3);
            end
            if (done_a) begin
                pulses_a++;
                if (lat_a < 0) begin lat_a = cyc; qa = quo_a; ea = err_a; end
            end
            if (done_b) begin
                pulses_b++;
                if (lat_b < 0) begin lat_b = cyc; qb = quo_b; eb = err_b; end
            end
        end
        chk(req, "quotient default", {16'd0, qa}, {16'd0, exp[15:0]});
        chk(req, "err default", {31'd0, ea}, {31'd0, exp[16]});
        chk("R9", "quotient alt", {16'd0, qb}, {16'd0, exp[15:0]});
        chk("R9", "err alt", {31'd0, eb}, {31'd0, exp[16]});
        chk(exp[16] ? "R5" : "R6", "latency default", 32'(lat_a), exp[16] ? 32'd1 : 32'd17);
        chk(exp[16] ? "R5" : "R6", "latency alt", 32'(lat_b), exp[16] ? 32'd1 : 32'd16);
        chk(poke ? "R7" : "R8", "done pulses default", 32'(pulses_a), 32'd1);
        chk(poke ? "R7" : "R8", "done pulses alt", 32'(pulses_b), 32'd1);
        chk("R8", "hold default", {15'd0, err_a, quo_a}, {15'd0, exp});
        chk("R8", "hold alt", {15'd0, err_b, quo_b}, {15'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] ra, rb;
        rst_n = 1'b0; start = 1'b0; dividend = '0; divisor = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset default", {13'd0, busy_a, done_a, err_a, quo_a}, 32'd0);
        chk("R1", "reset alt", {13'd0, busy_b, done_b, err_b, quo_b}, 32'd0);

        // Directed corners
        run_op(16'h0400, 16'h2000, 1'b0, "R9");   // expect 0x1000
        run_op(16'hFC00, 16'h2000, 1'b0, "R3");   // expect 0xF000
        run_op(16'hFC00, 16'hE000, 1'b0, "R3");   // both negative, expect 0x1000
        run_op(16'h7FFF, 16'h8000, 1'b0, "R4");   // expect 0x8001
        run_op(16'h8001, 16'h8000, 1'b0, "R4");   // expect 0x7FFF
        run_op(16'h8000, 16'h7FFF, 1'b0, "R5");   // rejected
        run_op(16'h1234, 16'h0000, 1'b0, "R5");   // zero divisor
        run_op(16'h0000, 16'h0000, 1'b0, "R5");   // zero over zero
        run_op(16'h2000, 16'h2000, 1'b0, "R5");   // equal magnitudes
        run_op(16'h2000, 16'hE000, 1'b0, "R5");   // opposite, equal magnitude
        run_op(16'h0000, 16'hFFFB, 1'b0, "R3");   // zero stays zero
        run_op(16'h0001, 16'h7FFF, 1'b0, "R2");   // expect 0x0001
        run_op(16'hFFFF, 16'h0002, 1'b0, "R5");   // |a|=1 < |b|=2 -> valid, expect 0xC000
        run_op(16'h3000, 16'h4000, 1'b1, "R7");   // start poked while busy

        // Constrained random
        void'($urandom(32'd20240611));
        for (int i = 0; i < 150; i++) begin
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (i % 2 == 1) ra = {{5{ra[15]}}, ra[10:0]};
            run_op(ra, rb, (i % 7 == 3) && (model(ra, rb) >> 16) == 17'd0, "R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule